// File: doc/BRIEF.md
# Memory Write Requester with Fence

This block sits between an accelerator's command logic and the write side of a host-memory channel. Each accepted command becomes one request on the transmit side: a one-cycle valid strobe together with a request kind, a write mode, byte-range fields, a cache-line address and a full line of data. The request kind carries one of three caching intents for the written line: no local caching, leave the line Modified in the local cache, or push the line into the processor-side cache. A command can instead ask for a fence. A fence goes out on the same channel with no address and no data, and it makes all earlier writes globally visible.

The paired response channel brings back write completions, fence completions and interrupt-type responses. The block keeps a count of writes that have not yet completed and caps it at a parameter. Once a fence has been issued, no new command is accepted until the fence completion arrives, and that arrival is reported with a one-cycle pulse. An almost-full signal from the channel stops commands from being accepted. Byte-enable writes carry a start offset and a byte length within the line. A parameter can remove byte-enable writes, and in that build every request goes out in line mode.

Top module: `mwr_fence_requester`

## Requirements
- R1: `cmd_ready_o` is high exactly when `almost_full_i` is low, no fence is pending and the outstanding count is below `MAX_OUT`. A command is accepted when `cmd_valid_i` and `cmd_ready_o` are both high at a clock edge. After that edge, `tx_valid_o` is high for one cycle, and the tx fields hold the command's address and data. In every other cycle `tx_valid_o` is low.
- R2: For a write, `tx_kind_o` encodes `cmd_hint_i` as follows. Hint 1 gives kind 1 (line kept Modified locally). Hint 2 gives kind 2 (push to the processor-side cache). Hint 0 and hint 3 both give kind 0 (no local caching).
- R3: An accepted command with `cmd_fence_i` high goes out as kind 3. Its address, data, mode, start and length fields are all zero.
- R4: From the edge that accepts a fence, `fence_pending_o` is high and `cmd_ready_o` is low. Both stay that way until a response of type 1 (fence completion) is received. In the cycle after that response, `fence_done_o` pulses high for one cycle, `fence_pending_o` falls and commands are accepted again.
- R5: `tx_byte_mode_o` is 1 for a byte-enable write and 0 for a line write. A byte-enable write carries `cmd_be_start_i` and `cmd_be_len_i` on the tx start and length fields. In line mode, and whenever `tx_valid_o` is low, every tx payload field is zero.
- R6: When `BYTE_MODE_EN` is 0, every write goes out with mode 0 and with zero start and length fields, whatever `cmd_byte_mode_i` says.
- R7: `outstanding_o` goes up by one after each accepted write; fences do not count. It goes down by one after each response of type 0 (write completion). If an increment and a decrement fall in the same cycle, they cancel.
- R8: When `outstanding_o` equals `MAX_OUT`, `cmd_ready_o` is low and the count never rises above `MAX_OUT`.
- R9: A write completion that arrives while `outstanding_o` is zero is ignored, and the count stays at zero.
- R10: A response of type 2 (interrupt) makes `intr_err_o` pulse for one cycle in the following cycle. It leaves `outstanding_o` unchanged.
- R11: A fence completion that arrives with no fence pending produces no `fence_done_o` pulse. A response of type 3 changes no output.
- R12: While reset is active, `tx_valid_o`, all tx fields, `outstanding_o`, `fence_pending_o`, `fence_done_o` and `intr_err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted this cycle |
| cmd_fence_i | input | 1 | Command is a fence |
| cmd_hint_i | input | 2 | Caching-intent hint |
| cmd_byte_mode_i | input | 1 | 1 = byte-enable write, 0 = line write |
| cmd_be_start_i | input | OFS_W | First enabled byte within the line |
| cmd_be_len_i | input | LEN_W | Number of enabled bytes |
| cmd_addr_i | input | ADDR_W | Cache-line address |
| cmd_data_i | input | LINE_W | Line payload |
| almost_full_i | input | 1 | Channel backpressure |
| tx_valid_o | output | 1 | Request strobe |
| tx_kind_o | output | 2 | Request kind: 0 line no-cache, 1 line modified, 2 push, 3 fence |
| tx_byte_mode_o | output | 1 | Write mode of the request |
| tx_be_start_o | output | OFS_W | Byte-range start |
| tx_be_len_o | output | LEN_W | Byte-range length |
| tx_addr_o | output | ADDR_W | Request address |
| tx_data_o | output | LINE_W | Request data |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_type_i | input | 2 | Response type: 0 write, 1 fence, 2 interrupt, 3 reserved |
| outstanding_o | output | CNT_W | Writes not yet completed |
| fence_pending_o | output | 1 | A fence awaits its completion |
| fence_done_o | output | 1 | One-cycle pulse on fence completion |
| intr_err_o | output | 1 | One-cycle pulse on an interrupt-type response |

## Verification
The assertions check, on every cycle, the properties that involve only a few cycles. A request appears only after an accepted command, and only when almost-full was low at that edge. A fence request carries an empty payload, and line-mode requests have zero byte fields. No command is accepted while a fence is pending, and the outstanding count moves by at most one per cycle and stays within its cap. Some checks need whole sequences of stimulus, and only the bench scenarios can show them. These are the hint encodings, running the count up to its cap and back down past zero, a fence blocking commands until its completion, stray fence completions, reserved and interrupt responses, and the build without byte-enable writes. The bench compares all of these against its reference model on every cycle.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [1:0] {
    REQ_LINE_NC  = 2'd0,
    REQ_LINE_MOD = 2'd1,
    REQ_PUSH_NC  = 2'd2,
    REQ_FENCE    = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RSP_WRITE = 2'd0,
    RSP_FENCE = 2'd1,
    RSP_INTR  = 2'd2,
    RSP_RSVD  = 2'd3
  } rsp_kind_e;

  function automatic req_kind_e hint_to_kind(input logic [1:0] hint);
    case (hint)
      2'd1:    return REQ_LINE_MOD;
      2'd2:    return REQ_PUSH_NC;
      default: return REQ_LINE_NC;
    endcase
  endfunction

endpackage

// File: rtl/mwr_hdr_build.sv
module mwr_hdr_build
  import mwr_pkg::*;
#(
  parameter int ADDR_W       = 42,
  parameter int LINE_BYTES   = 64,
  parameter bit BYTE_MODE_EN = 1'b1,
  localparam int LINE_W      = LINE_BYTES * 8,
  localparam int OFS_W       = $clog2(LINE_BYTES),
  localparam int LEN_W       = OFS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              fence_i,
  input  logic [1:0]        hint_i,
  input  logic              mode_i,
  input  logic [OFS_W-1:0]  start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINE_W-1:0] data_i,
  output logic              valid_o,
  output logic [1:0]        kind_o,
  output logic              mode_o,
  output logic [OFS_W-1:0]  start_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LINE_W-1:0] data_o
);

  logic              byte_sel;
  logic              valid_q;
  req_kind_e         kind_q;
  logic              mode_q;
  logic [OFS_W-1:0]  start_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q;

  generate
    if (BYTE_MODE_EN) begin : g_byte
      assign byte_sel = mode_i;
    end else begin : g_line_only
      assign byte_sel = 1'b0;
    end
  endgenerate

  // idle cycles drive an all-zero header
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      kind_q  <= REQ_LINE_NC;
      mode_q  <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= issue_i;
      kind_q  <= REQ_LINE_NC;
      mode_q  <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      if (issue_i && fence_i) begin
        kind_q <= REQ_FENCE;
      end else if (issue_i) begin
        kind_q <= hint_to_kind(hint_i);
        mode_q <= byte_sel;
        addr_q <= addr_i;
        data_q <= data_i;
        if (byte_sel) begin
          start_q <= start_i;
          len_q   <= len_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign kind_o  = kind_q;
  assign mode_o  = mode_q;
  assign start_o = start_q;
  assign len_o   = len_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

endmodule

// File: rtl/mwr_out_cnt.sv
module mwr_out_cnt #(
  parameter int MAX_OUT = 8,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             dec_ok;

  // completions with nothing outstanding are dropped
  assign dec_ok = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(MAX_OUT));

endmodule

// File: rtl/mwr_rsp_track.sv
module mwr_rsp_track
  import mwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rsp_valid_i,
  input  logic [1:0] rsp_type_i,
  input  logic       fence_issue_i,
  output logic       wr_done_o,
  output logic       fence_pend_o,
  output logic       fence_done_o,
  output logic       intr_o
);

  rsp_kind_e rsp_kind;
  logic      pend_q;
  logic      done_q;
  logic      intr_q;
  logic      fence_ack;

  assign rsp_kind  = rsp_kind_e'(rsp_type_i);
  assign wr_done_o = rsp_valid_i && (rsp_kind == RSP_WRITE);
  assign fence_ack = rsp_valid_i && (rsp_kind == RSP_FENCE) && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (fence_issue_i)  pend_q <= 1'b1;
      else if (fence_ack) pend_q <= 1'b0;
      done_q <= fence_ack;
      intr_q <= rsp_valid_i && (rsp_kind == RSP_INTR);
    end
  end

  assign fence_pend_o = pend_q;
  assign fence_done_o = done_q;
  assign intr_o       = intr_q;

endmodule

// File: rtl/mwr_fence_requester.sv
module mwr_fence_requester
  import mwr_pkg::*;
#(
  parameter int ADDR_W       = 42,
  parameter int LINE_BYTES   = 64,
  parameter int MAX_OUT      = 8,
  parameter bit BYTE_MODE_EN = 1'b1,
  localparam int LINE_W      = LINE_BYTES * 8,
  localparam int OFS_W       = $clog2(LINE_BYTES),
  localparam int LEN_W       = OFS_W + 1,
  localparam int CNT_W       = $clog2(MAX_OUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_fence_i,
  input  logic [1:0]        cmd_hint_i,
  input  logic              cmd_byte_mode_i,
  input  logic [OFS_W-1:0]  cmd_be_start_i,
  input  logic [LEN_W-1:0]  cmd_be_len_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LINE_W-1:0] cmd_data_i,
  input  logic              almost_full_i,
  output logic              tx_valid_o,
  output logic [1:0]        tx_kind_o,
  output logic              tx_byte_mode_o,
  output logic [OFS_W-1:0]  tx_be_start_o,
  output logic [LEN_W-1:0]  tx_be_len_o,
  output logic [ADDR_W-1:0] tx_addr_o,
  output logic [LINE_W-1:0] tx_data_o,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_type_i,
  output logic [CNT_W-1:0]  outstanding_o,
  output logic              fence_pending_o,
  output logic              fence_done_o,
  output logic              intr_err_o
);

  logic accept;
  logic cnt_full;
  logic wr_done;
  logic fence_pend;

  assign cmd_ready_o = !almost_full_i && !fence_pend && !cnt_full;
  assign accept      = cmd_valid_i && cmd_ready_o;

  mwr_hdr_build #(
    .ADDR_W      (ADDR_W),
    .LINE_BYTES  (LINE_BYTES),
    .BYTE_MODE_EN(BYTE_MODE_EN)
  ) u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(accept),
    .fence_i(cmd_fence_i),
    .hint_i (cmd_hint_i),
    .mode_i (cmd_byte_mode_i),
    .start_i(cmd_be_start_i),
    .len_i  (cmd_be_len_i),
    .addr_i (cmd_addr_i),
    .data_i (cmd_data_i),
    .valid_o(tx_valid_o),
    .kind_o (tx_kind_o),
    .mode_o (tx_byte_mode_o),
    .start_o(tx_be_start_o),
    .len_o  (tx_be_len_o),
    .addr_o (tx_addr_o),
    .data_o (tx_data_o)
  );

  mwr_out_cnt #(
    .MAX_OUT(MAX_OUT)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (accept && !cmd_fence_i),
    .dec_i (wr_done),
    .cnt_o (outstanding_o),
    .full_o(cnt_full)
  );

  mwr_rsp_track u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_type_i   (rsp_type_i),
    .fence_issue_i(accept && cmd_fence_i),
    .wr_done_o    (wr_done),
    .fence_pend_o (fence_pend),
    .fence_done_o (fence_done_o),
    .intr_o       (intr_err_o)
  );

  assign fence_pending_o = fence_pend;

endmodule

// File: rtl/mwr_fence_requester_chk.sv
module mwr_fence_requester_chk #(
  parameter int ADDR_W     = 42,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFS_W + 1,
  localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              almost_full_i,
  input logic              tx_valid_o,
  input logic [1:0]        tx_kind_o,
  input logic              tx_byte_mode_o,
  input logic [OFS_W-1:0]  tx_be_start_o,
  input logic [LEN_W-1:0]  tx_be_len_o,
  input logic [ADDR_W-1:0] tx_addr_o,
  input logic [LINE_W-1:0] tx_data_o,
  input logic [CNT_W-1:0]  outstanding_o,
  input logic              fence_pending_o,
  input logic              fence_done_o,
  input logic              intr_err_o
);

  assert_issue_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(cmd_valid_i && cmd_ready_o));

  assert_accept_issues_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> tx_valid_o);

  assert_no_issue_almfull_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !$past(almost_full_i));

  assert_fence_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_kind_o == 2'd3) |->
      (tx_addr_o == '0 && tx_data_o == '0 && !tx_byte_mode_o
       && tx_be_start_o == '0 && tx_be_len_o == '0));

  assert_pending_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_pending_o |-> !cmd_ready_o);

  assert_fence_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |-> ($past(fence_pending_o) && !fence_pending_o));

  assert_line_be_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_byte_mode_o |-> (tx_be_start_o == '0 && tx_be_len_o == '0));

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(outstanding_o) <= int'($past(outstanding_o)) + 1)
    && (int'(outstanding_o) + 1 >= int'($past(outstanding_o))));

  assert_cnt_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(outstanding_o) <= MAX_OUT)
    && ((int'(outstanding_o) == MAX_OUT) -> !cmd_ready_o));

  assert_intr_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_err_o |-> !fence_done_o);

endmodule

bind mwr_fence_requester mwr_fence_requester_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .MAX_OUT   (MAX_OUT)
) chk_i (.*);

// File: tb/mwr_fence_requester_tb_top.sv
`timescale 1ns/1ps
module mwr_fence_requester_tb_top;

  localparam int ADDR_W     = 42;
  localparam int LINE_BYTES = 64;
  localparam int MAX_OUT    = 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int LEN_W      = OFS_W + 1;
  localparam int CNT_W      = $clog2(MAX_OUT + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic              cmd_fence_i = 1'b0;
  logic [1:0]        cmd_hint_i = '0;
  logic              cmd_byte_mode_i = 1'b0;
  logic [OFS_W-1:0]  cmd_be_start_i = '0;
  logic [LEN_W-1:0]  cmd_be_len_i = '0;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic [LINE_W-1:0] cmd_data_i = '0;
  logic              almost_full_i = 1'b0;
  logic              rsp_valid_i = 1'b0;
  logic [1:0]        rsp_type_i = '0;

  wire              cmd_ready_o, tx_valid_o, tx_byte_mode_o;
  wire [1:0]        tx_kind_o;
  wire [OFS_W-1:0]  tx_be_start_o;
  wire [LEN_W-1:0]  tx_be_len_o;
  wire [ADDR_W-1:0] tx_addr_o;
  wire [LINE_W-1:0] tx_data_o;
  wire [CNT_W-1:0]  outstanding_o;
  wire              fence_pending_o, fence_done_o, intr_err_o;

  wire              nb_ready, nb_valid, nb_mode, nb_pend, nb_done, nb_intr;
  wire [1:0]        nb_kind;
  wire [OFS_W-1:0]  nb_start;
  wire [LEN_W-1:0]  nb_len;
  wire [ADDR_W-1:0] nb_addr;
  wire [LINE_W-1:0] nb_data;
  wire [CNT_W-1:0]  nb_cnt;

  always #10 clk_i = ~clk_i;

  mwr_fence_requester dut_i (.*);

  mwr_fence_requester #(.BYTE_MODE_EN(1'b0)) dut_nobe_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(nb_ready),
    .cmd_fence_i(cmd_fence_i), .cmd_hint_i(cmd_hint_i), .cmd_byte_mode_i(cmd_byte_mode_i),
    .cmd_be_start_i(cmd_be_start_i), .cmd_be_len_i(cmd_be_len_i), .cmd_addr_i(cmd_addr_i),
    .cmd_data_i(cmd_data_i), .almost_full_i(almost_full_i), .tx_valid_o(nb_valid),
    .tx_kind_o(nb_kind), .tx_byte_mode_o(nb_mode), .tx_be_start_o(nb_start),
    .tx_be_len_o(nb_len), .tx_addr_o(nb_addr), .tx_data_o(nb_data),
    .rsp_valid_i(rsp_valid_i), .rsp_type_i(rsp_type_i), .outstanding_o(nb_cnt),
    .fence_pending_o(nb_pend), .fence_done_o(nb_done), .intr_err_o(nb_intr));

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit              m_v, m_mode, m_fpend, m_fdone, m_err;
  int              m_kind, m_cnt;
  logic [OFS_W-1:0]  m_start;
  logic [LEN_W-1:0]  m_len;
  logic [ADDR_W-1:0] m_addr;
  logic [LINE_W-1:0] m_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return !almost_full_i && !m_fpend && (m_cnt < MAX_OUT);
  endfunction

  task automatic model_reset();
    m_v = 0; m_mode = 0; m_fpend = 0; m_fdone = 0; m_err = 0;
    m_kind = 0; m_cnt = 0; m_start = '0; m_len = '0; m_addr = '0; m_data = '0;
  endtask

  task automatic model_update();
    bit acc;
    bit wr_c;
    acc  = cmd_valid_i && m_ready();
    wr_c = rsp_valid_i && rsp_type_i == 2'd0;
    m_fdone = rsp_valid_i && rsp_type_i == 2'd1 && m_fpend;
    m_err   = rsp_valid_i && rsp_type_i == 2'd2;
    if (acc && cmd_fence_i) m_fpend = 1;
    else if (m_fdone) m_fpend = 0;
    if (wr_c && m_cnt > 0) m_cnt--;
    if (acc && !cmd_fence_i) m_cnt++;
    m_v = acc; m_kind = 0; m_mode = 0; m_start = '0; m_len = '0; m_addr = '0; m_data = '0;
    if (acc && cmd_fence_i) m_kind = 3;
    else if (acc) begin
      m_kind = (cmd_hint_i == 2'd3) ? 0 : int'(cmd_hint_i);
      m_mode = cmd_byte_mode_i;
      m_addr = cmd_addr_i;
      m_data = cmd_data_i;
      if (m_mode) begin m_start = cmd_be_start_i; m_len = cmd_be_len_i; end
    end
  endtask

  task automatic compare();
    string tag;
    tag = (m_kind == 3) ? "R3" : "R1";
    chk(cmd_ready_o == m_ready(), "R1", "ready", 64'(cmd_ready_o), 64'(m_ready()));
    chk(tx_valid_o == m_v, "R1", "tx_valid", 64'(tx_valid_o), 64'(m_v));
    chk(int'(tx_kind_o) == m_kind, "R2", "kind", 64'(tx_kind_o), 64'(m_kind));
    chk(tx_addr_o == m_addr, tag, "addr", 64'(tx_addr_o), 64'(m_addr));
    chk(tx_data_o == m_data, tag, "data", tx_data_o[63:0], m_data[63:0]);
    chk(tx_byte_mode_o == m_mode && tx_be_start_o == m_start && tx_be_len_o == m_len,
        "R5", "mode/start/len", {56'(tx_byte_mode_o), tx_be_start_o, 1'b0, tx_be_len_o},
        {56'(m_mode), m_start, 1'b0, m_len});
    chk(int'(outstanding_o) == m_cnt, "R7", "outstanding", 64'(outstanding_o), 64'(m_cnt));
    chk(fence_pending_o == m_fpend && fence_done_o == m_fdone, "R4", "fence pend/done",
        {fence_pending_o, fence_done_o}, {m_fpend, m_fdone});
    chk(intr_err_o == m_err, "R10", "intr_err", 64'(intr_err_o), 64'(m_err));
    chk(nb_valid == m_v && !nb_mode && nb_start == '0 && nb_len == '0 && int'(nb_kind) == m_kind,
        "R6", "line-only build", {nb_valid, nb_mode, nb_kind}, {m_v, 1'b0, 2'(m_kind)});
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
  endtask

  task automatic rand_payload();
    cmd_addr_i = {$urandom, $urandom};
    for (int i = 0; i < LINE_W / 32; i++) cmd_data_i[i*32 +: 32] = $urandom;
  endtask

  task automatic send(input bit fence, input logic [1:0] hint, input bit bmode,
                      input int start, input int len);
    cmd_fence_i = fence; cmd_hint_i = hint; cmd_byte_mode_i = bmode;
    cmd_be_start_i = OFS_W'(start); cmd_be_len_i = LEN_W'(len);
    rand_payload();
    cmd_valid_i = 1;
    step();
    cmd_valid_i = 0;
  endtask

  task automatic resp(input logic [1:0] t);
    rsp_valid_i = 1; rsp_type_i = t;
    step();
    rsp_valid_i = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog: actual %0d expected 0", 1);
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(!tx_valid_o && tx_kind_o == 0 && tx_addr_o == 0 && tx_data_o == 0 && outstanding_o == 0
        && !fence_pending_o && !fence_done_o && !intr_err_o && !tx_byte_mode_o,
        "R12", "reset outputs", {tx_valid_o, outstanding_o, fence_pending_o}, 64'd0);
    rst_ni = 1;
    step();

    // hints on line writes
    for (int h = 0; h < 4; h++) send(0, 2'(h), 0, 0, 0);
    step();
    // byte-enable writes
    send(0, 2'd1, 1, 5, 10);
    send(0, 2'd2, 1, 0, 64);
    send(0, 2'd0, 0, 7, 3);   // line mode ignores start/len
    // simultaneous accept and completion
    rsp_valid_i = 1; rsp_type_i = 2'd0;
    send(0, 2'd0, 0, 0, 0);
    rsp_valid_i = 0;
    step();
    chk(outstanding_o == 7, "R7", "net zero on accept+completion", 64'(outstanding_o), 64'd7);

    // backpressure
    almost_full_i = 1; cmd_valid_i = 1; cmd_fence_i = 0;
    repeat (3) step();
    chk(!tx_valid_o && !cmd_ready_o, "R1", "stalled by almost-full", 64'(tx_valid_o), 64'd0);
    almost_full_i = 0;

    // fill to cap
    for (int i = 0; i < 4; i++) begin rand_payload(); step(); end
    cmd_valid_i = 0;
    step();
    chk(outstanding_o == MAX_OUT && !cmd_ready_o, "R8", "cap reached",
        64'(outstanding_o), 64'(MAX_OUT));

    // drain past zero
    for (int i = 0; i < MAX_OUT + 2; i++) resp(2'd0);
    step();
    chk(outstanding_o == 0, "R9", "no underflow", 64'(outstanding_o), 64'd0);

    // fence blocks until completion
    send(1, 2'd2, 1, 3, 4);
    chk(fence_pending_o && !cmd_ready_o, "R4", "fence pending", 64'(fence_pending_o), 64'd1);
    cmd_valid_i = 1; cmd_fence_i = 0;
    repeat (3) step();
    chk(!tx_valid_o, "R4", "write held behind fence", 64'(tx_valid_o), 64'd0);
    cmd_valid_i = 0;
    resp(2'd1);
    chk(fence_done_o && !fence_pending_o && cmd_ready_o, "R4", "fence completion",
        {fence_done_o, fence_pending_o, cmd_ready_o}, 64'b101);
    step();
    chk(!fence_done_o, "R4", "single pulse", 64'(fence_done_o), 64'd0);

    // stray fence completion and reserved type
    resp(2'd1);
    chk(!fence_done_o, "R11", "stray fence completion", 64'(fence_done_o), 64'd0);
    send(0, 2'd1, 0, 0, 0);
    resp(2'd2);
    chk(intr_err_o && outstanding_o == 1, "R10", "interrupt flagged",
        {intr_err_o, outstanding_o}, {1'b1, CNT_W'(1)});
    resp(2'd3);
    chk(!intr_err_o && !fence_done_o && outstanding_o == 1, "R11", "reserved ignored",
        {intr_err_o, fence_done_o, outstanding_o}, {2'b00, CNT_W'(1)});

    // random traffic
    for (int i = 0; i < 600; i++) begin
      cmd_valid_i = $urandom_range(0, 3) != 0;
      cmd_fence_i = $urandom_range(0, 9) == 0;
      cmd_hint_i = 2'($urandom);
      cmd_byte_mode_i = 1'($urandom);
      cmd_be_start_i = OFS_W'($urandom);
      cmd_be_len_i = LEN_W'($urandom_range(0, LINE_BYTES));
      almost_full_i = $urandom_range(0, 4) == 0;
      rsp_valid_i = 1'($urandom);
      rsp_type_i = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'($urandom_range(0, 1));
      rand_payload();
      step();
    end
    cmd_valid_i = 0; rsp_valid_i = 0; almost_full_i = 0;
    step();

    summary();
    $finish;
  end

endmodule